// File: doc/BRIEF.md
# Display Timing Register Bank

This block is the software-visible parameter store of a raster display controller. A simple word-wide register port selects one of up to 32 registers by address. The bank holds the vertical and horizontal timing values, the frame buffer start address, the row pitch, a pixel-clock divide count, a set of enable flags and an interrupt enable word. Every write is cut down to the field of the register it lands in. Bits that fall outside that field are discarded and raise a sticky error flag. All stored values drive the timing generator and the fetch engine downstream.

Software cannot switch the display on or off with a single write. The control word must first be loaded with the wanted on/off bit. The strobe bit is then toggled three times. Only then does the display-enable level follow the inverse of that bit. While the display runs, any write to a parameter that shapes the raster produces a one-cycle reload pulse, so the timing generator picks up the new values.

A vertical-blank input is mirrored into two status bits. It is forwarded as an interrupt request when the display is on and the interrupt enable allows it.

Top module: `disp_regbank`

## Requirements
- R1: The register number is taken from address bits [8:4]. Address bits [3:0] and bits above bit 8 are ignored, so the 512-byte window aliases across the whole address space.
- R2: The timing registers are numbers 1 to 16 (default count). Each keeps the low 12 bits of a write. Register 8 keeps only 10 bits and register 14 keeps only 8 bits. Every timing register reads back its stored value zero-extended.
- R3: Register 19 (frame base) keeps only written bits [21:5]. Register 20 (row pitch) keeps only bits [14:5]. All other bits read back as zero.
- R4: Register 23 (clock divide) keeps 2 bits. Register 25 (interrupt enable) keeps 4 bits. Register 22 (flags) keeps 12 bits. Register 18 (display control word) keeps 11 bits.
- R5: Register 0 (current line) and register 17 (counter test) always read zero. Register 26 (interrupt status) ignores writes. Unassigned numbers read zero, and writes to them change no output.
- R6: A control-word write whose bit 10 differs from the stored word stores the value and clears the strobe count. A write that keeps bit 10 but changes any other bit stores the value and advances the count, saturating at 3. A write equal to the stored word does nothing.
- R7: When a counted write brings the strobe count to 3, or arrives while the count is already 3, and bit 10 differs from the last accepted bit 10, the display-enable output becomes the inverse of bit 10 on the next cycle. The written bit is then accepted. The accepted bit resets to 1, so the first change after reset is a switch-on, which requires bit 10 = 0.
- R8: Interrupt status bits [3:2] (register 26) are both 1 in the cycle after the vertical-blank input is high, and both 0 in the cycle after it is low. Every other status bit reads 0.
- R9: The interrupt request is high exactly when the status bits are set, display enable is high and interrupt-enable bit 2 is set.
- R10: A write to a timing, frame base, row pitch or clock divide register while display enable is high raises the reload output for exactly the following cycle. No other write raises it.
- R11: A write that sets any bit outside the field of a writable register (R2 to R4) sets the error output. The output stays set until reset.
- R12: After reset all stored registers, display enable, reload, interrupt request and the error output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| vblank_in | input | 1 | Vertical-blank level from the timing generator |
| tim_flat | output | NTIM*TIM_W (192) | Timing registers, slot k at bits [k*TIM_W +: TIM_W] |
| fb_base | output | BASE_HI+1 (22) | Frame buffer base address |
| row_pitch | output | PITCH_HI+1 (15) | Row pitch in bytes |
| clk_div | output | DIV_W (2) | Pixel-clock divide count |
| flags | output | FLAG_W (12) | Enable flags |
| disp_en | output | 1 | Display enable level |
| reload | output | 1 | One-cycle parameter reload pulse |
| irq | output | 1 | Vertical-blank interrupt request |
| field_err | output | 1 | Sticky out-of-field write flag |

## Verification
The bench builds the bank with its default parameters: sixteen 12-bit timing slots, a 10-bit slot at number 8 and an 8-bit slot at number 14, 32-bit data, 12-bit addresses and a strobe count of three. With these values, the narrow-slot generate branches are exercised. Addresses with bits 11:9 set reach the alias behaviour. Complete three-toggle handshakes fit in a few cycles, so switch-on, switch-off and a count interrupted by a bit-10 change can all be driven. The control word, interrupt enable and status registers land at their fixed numbers, so their masks are checked at the ports.

// File: rtl/disp_regbank_pkg.sv
package disp_regbank_pkg;

   // Register number field position inside the byte address
   localparam int unsigned RSEL_LO = 4;
   localparam int unsigned RSEL_W  = 5;

   // First timing register number
   localparam int unsigned TIM_BASE = 1;

   // Build a mask with bits [hi:lo] set in a word of width w
   function automatic logic [63:0] field_mask(input int unsigned hi, input int unsigned lo);
      logic [63:0] m;
      m = '0;
      for (int unsigned b = 0; b < 64; b++) begin
         if (b >= lo && b <= hi) m[b] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/disp_timing_bank.sv
module disp_timing_bank
   import disp_regbank_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned NTIM      = 16,
   parameter int unsigned TIM_W     = 12,
   parameter int unsigned PIPE_SLOT = 7,
   parameter int unsigned PIPE_W    = 10,
   parameter int unsigned HEQ_SLOT  = 13,
   parameter int unsigned HEQ_W     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [RSEL_W-1:0]        sel,
   input  logic [DATA_W-1:0]        wdata,
   output logic [NTIM*TIM_W-1:0]    tim_flat,
   output logic                     any_hit,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     wr_err
);

   logic [NTIM-1:0]   hit;
   logic [NTIM-1:0]   slot_err;
   logic [DATA_W-1:0] slot_rd [NTIM];

   for (genvar k = 0; k < NTIM; k++) begin : g_slot
      // Slot width: narrow variants for the pipeline delay and equalization slots
      localparam int unsigned W = (k == PIPE_SLOT) ? PIPE_W :
                                  ((k == HEQ_SLOT) ? HEQ_W : TIM_W);
      localparam logic [DATA_W-1:0] FMASK = DATA_W'(field_mask(W - 1, 0));

      logic [TIM_W-1:0] q;

      assign hit[k] = (sel == RSEL_W'(TIM_BASE + k));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && hit[k]) begin
            q <= wdata[TIM_W-1:0] & FMASK[TIM_W-1:0];
         end
      end

      assign slot_rd[k]  = hit[k] ? DATA_W'(q) : '0;
      assign slot_err[k] = wr_en & hit[k] & (|(wdata & ~FMASK));
      assign tim_flat[k*TIM_W +: TIM_W] = q;

      // R2: a stored slot never holds bits beyond its own width
      if (W < TIM_W) begin : g_narrow_chk
         p_slot_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && hit[k]) |=> (q[TIM_W-1:W] == '0));
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NTIM; k++) begin
         rd_data = rd_data | slot_rd[k];
      end
   end

   assign any_hit = |hit;
   assign wr_err  = |slot_err;

endmodule

// File: rtl/disp_strobe_ctl.sv
module disp_strobe_ctl #(
   parameter int unsigned TEST_W   = 11,
   parameter int unsigned SW_BIT   = 10,
   parameter int unsigned STRB_CNT = 3,
   parameter logic [TEST_W-1:0] ACC_RST = 11'h433
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TEST_W-1:0] wval,
   output logic [TEST_W-1:0] test_q,
   output logic              disp_en
);

   localparam int unsigned CNT_W = $clog2(STRB_CNT + 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(STRB_CNT);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRB_CNT - 1);

   logic [CNT_W-1:0] cnt;
   logic             acc_bit;
   logic             en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         test_q  <= '0;
         cnt     <= '0;
         acc_bit <= ACC_RST[SW_BIT];
         en_q    <= 1'b0;
      end else if (wr_en && (wval != test_q)) begin
         test_q <= wval;
         if (wval[SW_BIT] != test_q[SW_BIT]) begin
            cnt <= '0;
         end else begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if ((cnt >= CNT_LAST) && (wval[SW_BIT] != acc_bit)) begin
               en_q    <= ~wval[SW_BIT];
               acc_bit <= wval[SW_BIT];
            end
         end
      end
   end

   assign disp_en = en_q;

   // R6: a change of the switch bit restarts the strobe count
   p_count_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wval[SW_BIT] != test_q[SW_BIT])) |=> (cnt == '0));

   // R7: the enable level only moves right after a control-word write
   p_en_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q != $past(en_q)) |-> $past(wr_en));

endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit #(
   parameter int unsigned STAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vblank,
   input  logic              disp_en,
   input  logic              ien_vbl,
   output logic [STAT_W-1:0] stat,
   output logic              irq
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat <= '0;
      end else begin
         stat <= {STAT_W{vblank}};
      end
   end

   assign irq = stat[0] & disp_en & ien_vbl;

   // R8: status follows the blanking input with one cycle of delay
   p_stat_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      vblank |=> (stat == {STAT_W{1'b1}}));
   p_stat_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !vblank |=> (stat == '0));

   // R9: a request only stands when blanking was seen on the previous edge
   p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(vblank));

endmodule

// File: rtl/disp_regbank.sv
module disp_regbank
   import disp_regbank_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NTIM      = 16,
   parameter int unsigned TIM_W     = 12,
   parameter int unsigned PIPE_SLOT = 7,
   parameter int unsigned PIPE_W    = 10,
   parameter int unsigned HEQ_SLOT  = 13,
   parameter int unsigned HEQ_W     = 8,
   parameter int unsigned BASE_HI   = 21,
   parameter int unsigned BASE_LO   = 5,
   parameter int unsigned PITCH_HI  = 14,
   parameter int unsigned PITCH_LO  = 5,
   parameter int unsigned DIV_W     = 2,
   parameter int unsigned IEN_W     = 4,
   parameter int unsigned FLAG_W    = 12,
   parameter int unsigned TEST_W    = 11,
   parameter int unsigned SW_BIT    = 10,
   parameter int unsigned STRB_CNT  = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_wr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic                  vblank_in,
   output logic [NTIM*TIM_W-1:0] tim_flat,
   output logic [BASE_HI:0]      fb_base,
   output logic [PITCH_HI:0]     row_pitch,
   output logic [DIV_W-1:0]      clk_div,
   output logic [FLAG_W-1:0]     flags,
   output logic                  disp_en,
   output logic                  reload,
   output logic                  irq,
   output logic                  field_err
);

   // Register numbers derived from the timing slot count
   localparam int unsigned N_CTEST = TIM_BASE + NTIM;
   localparam logic [RSEL_W-1:0] RI_LINE  = RSEL_W'(0);
   localparam logic [RSEL_W-1:0] RI_CTEST = RSEL_W'(N_CTEST);
   localparam logic [RSEL_W-1:0] RI_TEST  = RSEL_W'(N_CTEST + 1);
   localparam logic [RSEL_W-1:0] RI_BASE  = RSEL_W'(N_CTEST + 2);
   localparam logic [RSEL_W-1:0] RI_PITCH = RSEL_W'(N_CTEST + 3);
   localparam logic [RSEL_W-1:0] RI_FLAGS = RSEL_W'(N_CTEST + 5);
   localparam logic [RSEL_W-1:0] RI_DIV   = RSEL_W'(N_CTEST + 6);
   localparam logic [RSEL_W-1:0] RI_IEN   = RSEL_W'(N_CTEST + 8);
   localparam logic [RSEL_W-1:0] RI_ISTAT = RSEL_W'(N_CTEST + 9);

   localparam int unsigned STAT_LO = 2;
   localparam int unsigned STAT_W  = 2;
   localparam int unsigned IEN_VBL = 2;

   localparam logic [DATA_W-1:0] BASE_MASK  = DATA_W'(field_mask(BASE_HI, BASE_LO));
   localparam logic [DATA_W-1:0] PITCH_MASK = DATA_W'(field_mask(PITCH_HI, PITCH_LO));
   localparam logic [DATA_W-1:0] DIV_MASK   = DATA_W'(field_mask(DIV_W - 1, 0));
   localparam logic [DATA_W-1:0] IEN_MASK   = DATA_W'(field_mask(IEN_W - 1, 0));
   localparam logic [DATA_W-1:0] FLAG_MASK  = DATA_W'(field_mask(FLAG_W - 1, 0));
   localparam logic [DATA_W-1:0] TEST_MASK  = DATA_W'(field_mask(TEST_W - 1, 0));

   // Elaboration-time parameter checks
   if (ADDR_W < RSEL_LO + RSEL_W) begin : g_chk_addr
      $error("disp_regbank: ADDR_W too small for the register number field");
   end
   if (N_CTEST + 9 > 31) begin : g_chk_ntim
      $error("disp_regbank: NTIM leaves no room for the control registers");
   end
   if (TIM_W > DATA_W || BASE_HI >= DATA_W || PITCH_HI >= DATA_W) begin : g_chk_width
      $error("disp_regbank: a field exceeds the data width");
   end
   if (PIPE_W > TIM_W || HEQ_W > TIM_W) begin : g_chk_narrow
      $error("disp_regbank: narrow slot wider than a timing slot");
   end
   if (SW_BIT >= TEST_W || IEN_VBL >= IEN_W) begin : g_chk_bits
      $error("disp_regbank: control bit outside its register");
   end

   logic [RSEL_W-1:0] sel;
   logic              unused_addr;

   assign sel = bus_addr[RSEL_LO +: RSEL_W];
   assign unused_addr = &{1'b0, bus_addr[RSEL_LO-1:0], bus_addr[ADDR_W-1:RSEL_LO+RSEL_W]};

   // Timing slots
   logic              tim_hit;
   logic [DATA_W-1:0] tim_rd;
   logic              tim_err;

   disp_timing_bank #(
      .DATA_W(DATA_W), .NTIM(NTIM), .TIM_W(TIM_W),
      .PIPE_SLOT(PIPE_SLOT), .PIPE_W(PIPE_W),
      .HEQ_SLOT(HEQ_SLOT), .HEQ_W(HEQ_W)
   ) u_tim (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(sel), .wdata(bus_wdata),
      .tim_flat(tim_flat), .any_hit(tim_hit), .rd_data(tim_rd), .wr_err(tim_err)
   );

   // Control word handshake
   logic [TEST_W-1:0] test_q;
   logic              test_wr;

   assign test_wr = bus_wr && (sel == RI_TEST);

   disp_strobe_ctl #(
      .TEST_W(TEST_W), .SW_BIT(SW_BIT), .STRB_CNT(STRB_CNT),
      .ACC_RST(TEST_W'(11'h433))
   ) u_strb (
      .clk(clk), .rst_n(rst_n), .wr_en(test_wr),
      .wval(bus_wdata[TEST_W-1:0] & TEST_MASK[TEST_W-1:0]),
      .test_q(test_q), .disp_en(disp_en)
   );

   // Plain masked registers
   logic [BASE_HI:0]  base_q;
   logic [PITCH_HI:0] pitch_q;
   logic [DIV_W-1:0]  div_q;
   logic [FLAG_W-1:0] flags_q;
   logic [IEN_W-1:0]  ien_q;
   logic              reload_q;
   logic              err_q;
   logic              err_now;
   logic              raster_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         pitch_q <= '0;
         div_q   <= '0;
         flags_q <= '0;
         ien_q   <= '0;
      end else if (bus_wr) begin
         unique case (sel)
            RI_BASE:  base_q  <= bus_wdata[BASE_HI:0]  & BASE_MASK[BASE_HI:0];
            RI_PITCH: pitch_q <= bus_wdata[PITCH_HI:0] & PITCH_MASK[PITCH_HI:0];
            RI_DIV:   div_q   <= bus_wdata[DIV_W-1:0];
            RI_FLAGS: flags_q <= bus_wdata[FLAG_W-1:0];
            RI_IEN:   ien_q   <= bus_wdata[IEN_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      err_now = tim_err;
      if (bus_wr) begin
         unique case (sel)
            RI_BASE:  err_now = |(bus_wdata & ~BASE_MASK);
            RI_PITCH: err_now = |(bus_wdata & ~PITCH_MASK);
            RI_DIV:   err_now = |(bus_wdata & ~DIV_MASK);
            RI_FLAGS: err_now = |(bus_wdata & ~FLAG_MASK);
            RI_IEN:   err_now = |(bus_wdata & ~IEN_MASK);
            RI_TEST:  err_now = |(bus_wdata & ~TEST_MASK);
            default: ;
         endcase
      end
   end

   assign raster_hit = tim_hit || (sel == RI_BASE) || (sel == RI_PITCH) || (sel == RI_DIV);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         reload_q <= bus_wr && disp_en && raster_hit;
         err_q    <= err_q | err_now;
      end
   end

   // Interrupt path
   logic [STAT_W-1:0] stat;

   disp_irq_unit #(.STAT_W(STAT_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .vblank(vblank_in), .disp_en(disp_en),
      .ien_vbl(ien_q[IEN_VBL]), .stat(stat), .irq(irq)
   );

   // Read path
   always_comb begin
      bus_rdata = '0;
      if (tim_hit) begin
         bus_rdata = tim_rd;
      end else begin
         unique case (sel)
            RI_LINE:  bus_rdata = '0;
            RI_CTEST: bus_rdata = '0;
            RI_TEST:  bus_rdata = DATA_W'(test_q);
            RI_BASE:  bus_rdata = DATA_W'(base_q);
            RI_PITCH: bus_rdata = DATA_W'(pitch_q);
            RI_DIV:   bus_rdata = DATA_W'(div_q);
            RI_FLAGS: bus_rdata = DATA_W'(flags_q);
            RI_IEN:   bus_rdata = DATA_W'(ien_q);
            RI_ISTAT: bus_rdata = DATA_W'({stat, {STAT_LO{1'b0}}});
            default:  bus_rdata = '0;
         endcase
      end
   end

   assign fb_base   = base_q;
   assign row_pitch = pitch_q;
   assign clk_div   = div_q;
   assign flags     = flags_q;
   assign reload    = reload_q;
   assign field_err = err_q;

   // R10: a reload pulse is caused only by a write while the display was on
   p_reload_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reload |-> ($past(bus_wr) && $past(disp_en)));

   // R11: the error flag never clears on its own
   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      field_err |=> field_err);

   // R3: frame base alignment bits stay clear after any write to it
   p_base_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (sel == RI_BASE)) |=> (fb_base[BASE_LO-1:0] == '0));

endmodule

// File: tb/disp_regbank_tb_top.sv
module disp_regbank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        vblank_in = 1'b0;
   logic [191:0] tim_flat;
   logic [21:0] fb_base;
   logic [14:0] row_pitch;
   logic [1:0]  clk_div;
   logic [11:0] flags;
   logic        disp_en, reload, irq, field_err;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   disp_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vblank_in(vblank_in),
      .tim_flat(tim_flat), .fb_base(fb_base), .row_pitch(row_pitch),
      .clk_div(clk_div), .flags(flags), .disp_en(disp_en), .reload(reload),
      .irq(irq), .field_err(field_err)
   );

   // Watchdog
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 20000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic do_read(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // {write, address, write data, expected read}
   localparam int NV = 16;
   localparam logic [76:0] VEC [NV] = '{
      {1'b1, 12'h010, 32'hFFFF_FABC, 32'h0000_0ABC},  // R2 12-bit slot
      {1'b1, 12'h080, 32'h0000_0FFF, 32'h0000_03FF},  // R2 10-bit slot
      {1'b1, 12'h0E0, 32'h0000_0FFF, 32'h0000_00FF},  // R2 8-bit slot
      {1'b1, 12'h100, 32'h0000_0123, 32'h0000_0123},  // R2 last slot
      {1'b1, 12'h130, 32'hFFFF_FFFF, 32'h003F_FFE0},  // R3 base
      {1'b1, 12'h140, 32'hFFFF_FFFF, 32'h0000_7FE0},  // R3 pitch
      {1'b1, 12'h170, 32'h0000_000F, 32'h0000_0003},  // R4 divider
      {1'b1, 12'h190, 32'h0000_00FF, 32'h0000_000F},  // R4 int enable
      {1'b1, 12'h160, 32'h0000_FFFF, 32'h0000_0FFF},  // R4 flags
      {1'b1, 12'h000, 32'h0000_FFFF, 32'h0000_0000},  // R5 line
      {1'b1, 12'h110, 32'h0000_0055, 32'h0000_0000},  // R5 counter test
      {1'b1, 12'h1A0, 32'h0000_000C, 32'h0000_0000},  // R5 status read-only
      {1'b1, 12'h21C, 32'h0000_0456, 32'h0000_0456},  // R1 alias write
      {1'b0, 12'hE18, 32'h0000_0000, 32'h0000_0456},  // R1 alias read
      {1'b1, 12'h1F0, 32'h0000_FFFF, 32'h0000_0000},  // R5 unassigned
      {1'b1, 12'h0F0, 32'hFFFF_FFFF, 32'h0000_0FFF}   // R2 slot 15
   };

   logic [31:0] rd;

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 disp_en", {31'b0, disp_en}, 0);
      check("R12 irq/reload/err", {29'b0, irq, reload, field_err}, 0);
      check("R12 base", {10'b0, fb_base}, 0);
      rst_n = 1'b1;

      // R11: an in-field write leaves the error flag clear
      do_write(12'h130, 32'h0000_0020);
      check("R11 no error on clean write", {31'b0, field_err}, 0);
      // R10: no reload while the display is off
      do_write(12'h020, 32'h0000_0011);
      check("R10 no reload while off", {31'b0, reload}, 0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][76]) do_write(VEC[i][75:64], VEC[i][63:32]);
         else @(negedge clk);
         do_read(VEC[i][75:64], rd);
         check($sformatf("table vector %0d R1 R2 R3 R4 R5", i), rd, VEC[i][31:0]);
      end
      check("R3 base port", {10'b0, fb_base}, 32'h003F_FFE0);
      check("R2 narrow slot port", {20'b0, tim_flat[7*12 +: 12]}, 32'h3FF);
      check("R11 error set by table", {31'b0, field_err}, 1);

      // R6 and R7: handshake with an interrupted count
      do_write(12'h120, 32'h0000_0008);
      do_write(12'h120, 32'h0000_0000);
      do_write(12'h120, 32'h0000_0400);   // bit 10 change clears count
      do_write(12'h120, 32'h0000_0000);   // bit 10 change clears count
      do_write(12'h120, 32'h0000_0008);
      do_write(12'h120, 32'h0000_0000);
      check("R6 count cleared, still off", {31'b0, disp_en}, 0);
      do_write(12'h120, 32'h0000_0008);
      check("R7 third strobe switches on", {31'b0, disp_en}, 1);
      do_read(12'h120, rd);
      check("R6 control word stored", rd, 32'h8);
      do_write(12'h120, 32'h0000_0008);
      check("R6 identical write no effect", {31'b0, disp_en}, 1);

      // R10 reload pulse
      do_write(12'h030, 32'h0000_0042);
      check("R10 reload after timing write", {31'b0, reload}, 1);
      @(negedge clk);
      check("R10 reload lasts one cycle", {31'b0, reload}, 0);
      do_write(12'h190, 32'h0000_0004);
      check("R10 no reload for int enable", {31'b0, reload}, 0);

      // R8 and R9
      vblank_in = 1'b1;
      @(negedge clk);
      do_read(12'h1A0, rd);
      check("R8 status set", rd, 32'hC);
      check("R9 irq on", {31'b0, irq}, 1);
      do_write(12'h190, 32'h0000_0008);
      check("R9 irq masked by enable bit 2", {31'b0, irq}, 0);
      do_write(12'h190, 32'h0000_0004);
      vblank_in = 1'b0;
      @(negedge clk);
      do_read(12'h1A0, rd);
      check("R8 status cleared", rd, 32'h0);
      check("R9 irq off", {31'b0, irq}, 0);

      // R7 switch off
      do_write(12'h120, 32'h0000_0400);
      do_write(12'h120, 32'h0000_0408);
      do_write(12'h120, 32'h0000_0400);
      check("R7 still on before third strobe", {31'b0, disp_en}, 1);
      do_write(12'h120, 32'h0000_0408);
      check("R7 switched off", {31'b0, disp_en}, 0);
      vblank_in = 1'b1;
      @(negedge clk);
      check("R9 irq held off while display off", {31'b0, irq}, 0);
      vblank_in = 1'b0;

      // R11/R12: reset clears the sticky error
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check("R11 error cleared by reset", {31'b0, field_err}, 0);
      do_read(12'h010, rd);
      check("R12 timing cleared", rd, 0);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule